// File: doc/BRIEF.md
# 8-to-16-bit flash bus bridge

This block joins an 8-bit microcontroller to a 16-bit-wide parallel NOR flash. The microcontroller has a multiplexed address/data bus and a 16-bit address space. The flash has 20 word-address lines. The bridge latches the address on the address-latch strobe. It decodes the top three CPU address bits into four regions:

- a 13-bit flash window;
- a high-byte port;
- a bank-load port;
- a bank-increment port.

A seven-bit bank counter supplies the flash address bits that lie above the window.

Each 16-bit flash word moves as two byte transactions in a fixed order. For a write, software first writes the high byte to the high-byte port, where it is staged. It then writes the low byte into the flash window. That write starts one flash write cycle, which drives both bytes together.

For a read, a read in the flash window runs one flash read cycle. The low byte returns to the CPU directly, and the high byte is captured into a read latch. A later read of the high-byte port returns the captured byte.

The flash side uses separate data-out, data-in and output-enable signals in place of a bidirectional bus, together with active-low chip-enable, write-enable and output-enable. While a flash cycle runs, the bridge drops its ready output.

Top module: `flash_bus_bridge`

## Requirements
- R1: After reset the bridge is idle:
  - chip-enable, write-enable and output-enable are all high;
  - data-out enable is low and ready is high;
  - the bank counter (flash address bits 19..13) is zero.
- R2: The region is decoded from CPU address bits 15..13: 3'b100 is the flash window, 3'b101 the high-byte port, 3'b110 bank load and 3'b111 bank increment. Any access with other values leaves every flash strobe inactive and changes no state. A read of such an address returns 8'hFF, and so does a read of either bank port.
- R3: A write to the high-byte port stores the data byte as the staged high byte. The staged byte is kept across flash writes until it is next written.
- R4: A write in the flash window writes one word at flash address {bank, CPU A12..A0}. Data bits 7..0 carry the CPU data byte and bits 15..8 carry the staged high byte.
- R5: In a flash write cycle, chip-enable is low and data-out enable is high for one cycle before write-enable falls. Write-enable then stays low for exactly WE_CYCLES cycles (at least 2). Chip-enable and data-out enable remain asserted for one cycle after write-enable rises.
- R6: Data-out enable is high only while chip-enable is low and output-enable is high.
- R7: A read in the flash window holds chip-enable and output-enable low for exactly RD_CYCLES cycles. The low byte of the flash word is returned on the read-data output when ready returns high. The high byte is captured into the read latch.
- R8: A read of the high-byte port returns the high byte of the last flash read without starting a flash cycle. Before any flash read it returns 8'hFF.
- R9: A write to the bank-load port loads the bank counter with data bits 6..0.
- R10: A write to the bank-increment port adds one to the bank counter, wrapping from 127 to 0.
- R11: Ready is low from the cycle after a flash access is accepted until the flash cycle ends. Address-latch, write and read strobes that arrive while ready is low are ignored.
- R12: The flash address does not change while chip-enable stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_ale_i | input | 1 | Address latch strobe; captures cpu_ahi_i and cpu_ad_i |
| cpu_ahi_i | input | 8 | CPU address bits 15..8 |
| cpu_ad_i | input | 8 | Multiplexed low address / write data |
| cpu_wr_i | input | 1 | One-cycle write strobe |
| cpu_rd_i | input | 1 | One-cycle read strobe |
| cpu_rdata_o | output | 8 | Read data, valid when ready is high after a read |
| cpu_rdy_o | output | 1 | Bridge idle and able to accept a strobe |
| flash_addr_o | output | 20 | Flash word address |
| flash_dq_o | output | 16 | Data toward flash |
| flash_dq_i | input | 16 | Data from flash |
| flash_dq_oe_o | output | 1 | Drive enable for flash_dq_o |
| flash_ce_no | output | 1 | Flash chip-enable, active low |
| flash_we_no | output | 1 | Flash write-enable, active low |
| flash_oe_no | output | 1 | Flash output-enable, active low |

## Verification
The hardest case to reach is a CPU strobe that arrives in the middle of a running flash cycle. A well-behaved CPU never produces one, so the bench makes it on purpose. It starts a flash write, and while ready is low it pulses the address latch with a bank-load address and then pulses a write. Afterwards it checks three things: exactly one write-enable pulse appeared, the bank bits are unchanged, and the flash address stayed constant. The wrap of the bank counter and the 8'hFF returned by a high-byte read before any flash read are driven as directed cases. A seeded random mix of all operations then exercises the staged byte being reused over many flash writes.

// File: rtl/fbb_pkg.sv
package fbb_pkg;
  typedef enum logic [2:0] {
    RG_NONE,
    RG_FLASH,
    RG_HIBYTE,
    RG_BANK_LD,
    RG_BANK_INC
  } region_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_WSETUP,
    SQ_WPULSE,
    SQ_WHOLD,
    SQ_RPULSE
  } seq_state_e;
endpackage

// File: rtl/fbb_addr_decode.sv
module fbb_addr_decode
  import fbb_pkg::*;
#(
  parameter int          CPU_AW   = 16,
  parameter int          WIN_AW   = 13,
  parameter int          SEL_W    = CPU_AW - WIN_AW,
  parameter logic [SEL_W-1:0] SEL_FLASH = SEL_W'(4),
  parameter logic [SEL_W-1:0] SEL_HI    = SEL_W'(5),
  parameter logic [SEL_W-1:0] SEL_BLD   = SEL_W'(6),
  parameter logic [SEL_W-1:0] SEL_BINC  = SEL_W'(7)
) (
  input  logic [CPU_AW-1:0] addr_i,
  output region_e           region_o
);
  logic [SEL_W-1:0] sel;
  assign sel = addr_i[CPU_AW-1:WIN_AW];

  always_comb begin
    unique case (sel)
      SEL_FLASH: region_o = RG_FLASH;
      SEL_HI:    region_o = RG_HIBYTE;
      SEL_BLD:   region_o = RG_BANK_LD;
      SEL_BINC:  region_o = RG_BANK_INC;
      default:   region_o = RG_NONE;
    endcase
  end
endmodule

// File: rtl/fbb_byte_latch.sv
module fbb_byte_latch #(
  parameter int             DW      = 8,
  parameter logic [DW-1:0]  RST_VAL = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (ld_i) q_o <= d_i;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_i |=> $stable(q_o)); // R3
endmodule

// File: rtl/fbb_bank_ctr.sv
module fbb_bank_ctr #(
  parameter int BANK_W = 7,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              inc_i,
  input  logic [DW-1:0]     val_i,
  output logic [BANK_W-1:0] bank_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bank_o <= '0;
    else if (load_i)  bank_o <= val_i[BANK_W-1:0];
    else if (inc_i)   bank_o <= bank_o + BANK_W'(1);
  end

  AST_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> bank_o == $past(val_i[BANK_W-1:0])); // R9
  AST_BANK_INC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> bank_o == BANK_W'($past(bank_o) + 1)); // R10
endmodule

// File: rtl/fbb_flash_seq.sv
module fbb_flash_seq
  import fbb_pkg::*;
#(
  parameter int WE_CYCLES = 2,
  parameter int RD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_wr_i,
  input  logic start_rd_i,
  output logic busy_o,
  output logic cap_o,
  output logic ce_no,
  output logic we_no,
  output logic oe_no,
  output logic dq_oe_o
);
  localparam int MAXC  = (WE_CYCLES > RD_CYCLES) ? WE_CYCLES : RD_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_CYCLES - 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYCLES - 1);

  seq_state_e st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (start_wr_i)      st_q <= SQ_WSETUP;
          else if (start_rd_i) st_q <= SQ_RPULSE;
        end
        SQ_WSETUP: begin
          cnt_q <= '0;
          st_q  <= SQ_WPULSE;
        end
        SQ_WPULSE: begin
          if (cnt_q == WE_LAST) st_q <= SQ_WHOLD;
          else                  cnt_q <= cnt_q + CNT_W'(1);
        end
        SQ_WHOLD: st_q <= SQ_IDLE;
        SQ_RPULSE: begin
          if (cnt_q == RD_LAST) st_q <= SQ_IDLE;
          else                  cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o  = (st_q != SQ_IDLE);
  assign ce_no   = (st_q == SQ_IDLE);
  assign we_no   = (st_q != SQ_WPULSE);
  assign oe_no   = (st_q != SQ_RPULSE);
  assign dq_oe_o = (st_q == SQ_WSETUP) || (st_q == SQ_WPULSE) || (st_q == SQ_WHOLD);
  assign cap_o   = (st_q == SQ_RPULSE) && (cnt_q == RD_LAST);

  AST_WE_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |=> !we_no); // R5
  AST_WE_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_no) |-> $past(!ce_no && dq_oe_o)); // R5
  AST_WE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_no) |-> (!ce_no && dq_oe_o)); // R5
  AST_DQ_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!ce_no && oe_no)); // R6
  AST_RD_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> (!ce_no && !oe_no && we_no)); // R7
endmodule

// File: rtl/flash_bus_bridge.sv
module flash_bus_bridge
  import fbb_pkg::*;
#(
  parameter int CPU_AW    = 16,
  parameter int WIN_AW    = 13,
  parameter int FLASH_AW  = 20,
  parameter int DW        = 8,
  parameter int WE_CYCLES = 2,
  parameter int RD_CYCLES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cpu_ale_i,
  input  logic [CPU_AW-DW-1:0] cpu_ahi_i,
  input  logic [DW-1:0]        cpu_ad_i,
  input  logic                 cpu_wr_i,
  input  logic                 cpu_rd_i,
  output logic [DW-1:0]        cpu_rdata_o,
  output logic                 cpu_rdy_o,
  output logic [FLASH_AW-1:0]  flash_addr_o,
  output logic [2*DW-1:0]      flash_dq_o,
  input  logic [2*DW-1:0]      flash_dq_i,
  output logic                 flash_dq_oe_o,
  output logic                 flash_ce_no,
  output logic                 flash_we_no,
  output logic                 flash_oe_no
);
  localparam int BANK_W = FLASH_AW - WIN_AW;
  localparam int FW     = 2 * DW;

  logic [CPU_AW-1:0] addr_q;
  logic [DW-1:0]     wlo_q;
  logic [DW-1:0]     stage_hi;
  logic [DW-1:0]     read_hi;
  logic [BANK_W-1:0] bank;
  region_e           region;
  logic busy, cap;
  logic acc_wr, acc_rd;
  logic start_wr, start_rd;

  // CPU address latch; frozen while a flash cycle runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  addr_q <= '0;
    else if (cpu_ale_i && !busy)  addr_q <= {cpu_ahi_i, cpu_ad_i};
  end

  fbb_addr_decode #(.CPU_AW(CPU_AW), .WIN_AW(WIN_AW)) u_dec (
    .addr_i   (addr_q),
    .region_o (region)
  );

  assign acc_wr   = cpu_wr_i && !busy;
  assign acc_rd   = cpu_rd_i && !cpu_wr_i && !busy;
  assign start_wr = acc_wr && (region == RG_FLASH);
  assign start_rd = acc_rd && (region == RG_FLASH);

  fbb_byte_latch #(.DW(DW), .RST_VAL('0)) u_stage_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (acc_wr && (region == RG_HIBYTE)),
    .d_i    (cpu_ad_i),
    .q_o    (stage_hi)
  );

  fbb_byte_latch #(.DW(DW), .RST_VAL('1)) u_read_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (cap),
    .d_i    (flash_dq_i[FW-1:DW]),
    .q_o    (read_hi)
  );

  fbb_bank_ctr #(.BANK_W(BANK_W), .DW(DW)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (acc_wr && (region == RG_BANK_LD)),
    .inc_i   (acc_wr && (region == RG_BANK_INC)),
    .val_i   (cpu_ad_i),
    .bank_o  (bank)
  );

  fbb_flash_seq #(.WE_CYCLES(WE_CYCLES), .RD_CYCLES(RD_CYCLES)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_wr_i (start_wr),
    .start_rd_i (start_rd),
    .busy_o     (busy),
    .cap_o      (cap),
    .ce_no      (flash_ce_no),
    .we_no      (flash_we_no),
    .oe_no      (flash_oe_no),
    .dq_oe_o    (flash_dq_oe_o)
  );

  // low byte captured at acceptance, held through the write cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       wlo_q <= '0;
    else if (start_wr) wlo_q <= cpu_ad_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cpu_rdata_o <= '1;
    else if (cap)                         cpu_rdata_o <= flash_dq_i[DW-1:0];
    else if (acc_rd && region == RG_HIBYTE) cpu_rdata_o <= read_hi;
    else if (acc_rd && region != RG_FLASH)  cpu_rdata_o <= '1;
  end

  assign cpu_rdy_o    = !busy;
  assign flash_addr_o = {bank, addr_q[WIN_AW-1:0]};
  assign flash_dq_o   = {stage_hi, wlo_q};

  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flash_ce_no && $past(!flash_ce_no)) |-> $stable(flash_addr_o)); // R12
  AST_NO_STROBE_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cpu_wr_i || cpu_rd_i) && cpu_rdy_o && region == RG_NONE) |=> flash_ce_no); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flash_ce_no |-> !cpu_rdy_o); // R11
  AST_BUSY_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cpu_rdy_o && $past(!cpu_rdy_o)) |-> $stable(flash_addr_o[FLASH_AW-1:WIN_AW])); // R11
endmodule

// File: tb/tb_flash_bus_bridge.sv
module tb_flash_bus_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WE_CYC = 2;
  localparam int RD_CYC = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ale = 0, wr = 0, rd = 0;
  logic [7:0]  ahi = '0, ad = '0;
  logic [7:0]  rdata;
  logic        rdy;
  logic [19:0] faddr;
  logic [15:0] dq_o, dq_i = '0;
  logic        dq_oe, ce_n, we_n, oe_n;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_bus_bridge #(.WE_CYCLES(WE_CYC), .RD_CYCLES(RD_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_ale_i(ale), .cpu_ahi_i(ahi), .cpu_ad_i(ad),
    .cpu_wr_i(wr), .cpu_rd_i(rd), .cpu_rdata_o(rdata), .cpu_rdy_o(rdy),
    .flash_addr_o(faddr), .flash_dq_o(dq_o), .flash_dq_i(dq_i), .flash_dq_oe_o(dq_oe),
    .flash_ce_no(ce_n), .flash_we_no(we_n), .flash_oe_no(oe_n)
  );

  // device memory and reference model
  logic [15:0] mem [int];
  logic [15:0] expm [int];
  logic [6:0]  bank_m = '0;
  logic [7:0]  stage_m = '0;
  logic [7:0]  rdhi_m = 8'hFF;

  function automatic logic [15:0] dflt(input logic [19:0] a);
    return 16'(a * 20'h9E37) ^ {a[19:16], 12'h5A3};
  endfunction
  function automatic logic [15:0] dev_word(input logic [19:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
  endfunction
  function automatic logic [15:0] exp_word(input logic [19:0] a);
    return expm.exists(int'(a)) ? expm[int'(a)] : dflt(a);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // flash-side monitor
  logic        p_we = 1, p_ce = 1, p_oe = 1, p_dqoe = 0;
  logic [19:0] p_addr = '0;
  int we_cnt = 0, oe_cnt = 0, we_pulses = 0, ce_falls = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dq_oe && (ce_n || !oe_n)) chk("R6 dq_oe outside write", 1, 0);
      if (!ce_n && !p_ce && faddr !== p_addr) chk("R12 addr moved", faddr, p_addr);
      if (!ce_n && p_ce) ce_falls++;
      if (!we_n) begin
        we_cnt++;
        if (p_we) chk("R5 setup", {30'd0, p_ce, p_dqoe}, 32'h1);
      end else if (!p_we) begin
        chk("R5 we width", we_cnt, WE_CYC);
        chk("R5 hold", {30'd0, ce_n, dq_oe}, 32'h1);
        mem[int'(faddr)] = dq_o;
        we_pulses++;
        we_cnt = 0;
      end
      if (!oe_n) begin
        oe_cnt++;
        dq_i <= dev_word(faddr);
      end else begin
        dq_i <= '0;
        if (!p_oe) begin
          chk("R7 oe width", oe_cnt, RD_CYC);
          oe_cnt = 0;
        end
      end
    end
    p_we = we_n; p_ce = ce_n; p_oe = oe_n; p_dqoe = dq_oe; p_addr = faddr;
  end

  task automatic do_ale(input logic [15:0] a);
    @(negedge clk);
    ale = 1; ahi = a[15:8]; ad = a[7:0];
    @(negedge clk);
    ale = 0;
  endtask

  task automatic do_wr(input logic [15:0] a, input logic [7:0] d);
    do_ale(a);
    wr = 1; ad = d;
    @(negedge clk);
    wr = 0;
    while (!rdy) @(negedge clk);
    case (a[15:13])
      3'b100: expm[int'({bank_m, a[12:0]})] = {stage_m, d};
      3'b101: stage_m = d;
      3'b110: bank_m = d[6:0];
      3'b111: bank_m = bank_m + 7'd1;
      default: ;
    endcase
  endtask

  task automatic do_rd(input logic [15:0] a, output logic [7:0] d);
    logic [15:0] w;
    do_ale(a);
    rd = 1;
    @(negedge clk);
    rd = 0;
    while (!rdy) @(negedge clk);
    d = rdata;
    if (a[15:13] == 3'b100) begin
      w = exp_word({bank_m, a[12:0]});
      rdhi_m = w[15:8];
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [15:0] a);
    case (a[15:13])
      3'b100:  return exp_word({bank_m, a[12:0]}) & 16'hFF;
      3'b101:  return rdhi_m;
      default: return 8'hFF;
    endcase
  endfunction

  initial begin
    logic [7:0] d;
    int cf, wp;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ce_n", ce_n, 1); chk("R1 we_n", we_n, 1); chk("R1 oe_n", oe_n, 1);
    chk("R1 dq_oe", dq_oe, 0); chk("R1 rdy", rdy, 1); chk("R1 bank", faddr[19:13], 0);
    // R8 high-byte read before any flash read
    do_rd(16'hA000, d); chk("R8 hi before read", d, 8'hFF);
    // R3/R4 staged write then flash write
    do_wr(16'hA000, 8'hC3);
    do_wr(16'h8005, 8'h3C);
    chk("R4 word", mem.exists(5) ? mem[5] : 16'hxxxx, 16'hC33C);
    do_wr(16'h9FFF, 8'h11);
    chk("R3 stage reused", mem.exists(20'h1FFF) ? mem[20'h1FFF] : 16'hxxxx, 16'hC311);
    // R7 read back, R8 captured high byte
    do_rd(16'h8005, d); chk("R7 low byte", d, 8'h3C);
    do_rd(16'hA000, d); chk("R8 hi byte", d, 8'hC3);
    // R9 load, R10 increment and wrap
    do_wr(16'hC000, 8'hFF); chk("R9 bank load", faddr[19:13], 7'h7F);
    do_wr(16'hE000, 8'h00); chk("R10 wrap", faddr[19:13], 7'h00);
    do_wr(16'hE123, 8'h55); chk("R10 inc", faddr[19:13], 7'h01);
    do_wr(16'hC000, 8'h85); chk("R9 bank load masked", faddr[19:13], 7'h05);
    do_wr(16'h8010, 8'h77);
    chk("R4 bank addr", mem.exists(int'({7'h05, 13'h0010})) ? 32'(mem[int'({7'h05, 13'h0010})]) : 32'hDEAD, 32'hC377);
    // R2 outside regions
    cf = ce_falls;
    do_wr(16'h2000, 8'h99); do_wr(16'h7FFF, 8'h01);
    do_rd(16'h4000, d); chk("R2 outside read", d, 8'hFF);
    do_rd(16'hC000, d); chk("R2 bank port read", d, 8'hFF);
    chk("R2 no strobe", ce_falls - cf, 0);
    chk("R2 state kept", faddr[19:13], 7'h05);
    do_rd(16'hA000, d); chk("R2 hi kept", d, rdhi_m);
    // R11 strobes while busy are ignored
    wp = we_pulses;
    do_ale(16'h8020);
    wr = 1; ad = 8'h42;
    @(negedge clk);
    wr = 0;
    chk("R11 rdy low", rdy, 0);
    ale = 1; ahi = 8'hC0; ad = 8'h00;
    @(negedge clk);
    ale = 0; wr = 1; ad = 8'h13;
    @(negedge clk);
    wr = 0; rd = 1;
    @(negedge clk);
    rd = 0;
    while (!rdy) @(negedge clk);
    expm[int'({bank_m, 13'h0020})] = {stage_m, 8'h42};
    repeat (2) @(negedge clk);
    chk("R11 single pulse", we_pulses - wp, 1);
    chk("R11 bank kept", faddr[19:13], bank_m);
    chk("R11 addr kept", faddr[12:0], 13'h0020);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      logic [7:0]  x;
      int op;
      op = $urandom % 8;
      x  = 8'($urandom);
      case ($urandom % 4)
        0: a = 16'h8000;
        1: a = 16'h9FFF;
        default: a = {3'b100, 13'($urandom)};
      endcase
      case (op)
        0, 1: do_wr(a, x);
        2:    do_wr(16'hA000 | 16'($urandom % 16'h2000), x);
        3:    do_wr(16'hC000, x);
        4:    do_wr(16'hE000, x);
        5:    begin do_rd(a, d); chk("R7 random low", d, exp_rd(a)); end
        6:    begin do_rd(16'hA000, d); chk("R8 random hi", d, rdhi_m); end
        default: begin
          a = {1'b0, 15'($urandom)};
          do_wr(a, x);
          do_rd(a, d); chk("R2 random outside", d, 8'hFF);
        end
      endcase
      chk("R9 R10 bank track", faddr[19:13], bank_m);
    end
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule